// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the programming-mode logic in front of a 2 KB on-chip code flash. An external programmer raises a programming-enable input, selects an operation with a high-voltage-enable level and four mode pins, and presents bytes on an 8-bit data port. The programmer never supplies an address. An internal 11-bit counter clears each time programming is entered, and it steps by one on every pulse of a step input. Each operation acts on the byte that the counter points to.

Supported operations are a self-timed byte write, a code read used for verify, writes of two protection bits, a chip erase and a signature read. A byte write is started by the rising edge of an active-low program strobe. The ready output reports when the write has finished. While the write runs, a read of that byte returns its bit 7 inverted, which gives a second way to poll for completion. The first protection bit blocks further byte writes. With both protection bits set, code reads are blocked as well. Only a chip erase, which needs the strobe held low for a long interval, clears the protection bits.

The flash cells are modelled as a register array. A programmed byte becomes the AND of its old and new contents. Write and erase durations are counted in clock cycles and are set by parameters. A system reset returns the model to a blank, unprotected state. The data port is split into an input, an output and an output-enable for the pad ring.

Top module: `fpc_flash_prog`

## Requirements
- R1: The address counter clears to 0 on a rising edge of `pgm_en`. Each rising edge of `step_in` while `pgm_en` is high advances it by one, and it wraps from 7FFh to 000h.
- R2: Operations are selected by {`hv_en`,`mode_sel`}: 1_1110 write code, 0_1100 read code, 1_1111 write protection bit 1, 1_1100 write protection bit 2, 1_1000 chip erase, 0_0000 read signature. Any other combination, or `pgm_en` low, selects nothing. With nothing selected, strobes have no effect and `data_oe` stays low.
- R3: In write-code mode, a rising edge of `strobe_n` latches `data_in` and the current address. The stored byte becomes (old AND new). `ready` is low for exactly WRITE_CYC samples, starting the cycle after the edge, and the new content is readable once `ready` is high again.
- R4: While a code write is busy, a code read of the address being written returns the latched data with bit 7 inverted. After completion the true stored byte is returned.
- R5: Strobe edges that arrive while `ready` is low are ignored. The write in progress commits its original data.
- R6: In erase mode, holding `strobe_n` low for ERASE_CYC clock cycles sets every byte to FFh and clears both protection bits. A hold of ERASE_CYC-1 cycles changes nothing.
- R7: Once protection bit 1 is set, write-code strobes are refused. `ready` stays high and the byte keeps its value.
- R8: With both protection bits set, code reads leave `data_oe` low. With protection bit 1 alone set, code reads still return data.
- R9: In signature mode, address 000h returns 1Eh, address 001h returns 21h and every other address returns 00h, with `data_oe` high.
- R10: `data_oe` is high only in read-code or signature mode while `pgm_en` is high.
- R11: After system reset, `ready` is high, `data_oe` is low, every byte reads FFh and neither protection bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_en | input | 1 | Programming enable; rising edge clears the address |
| step_in | input | 1 | Address step; rising edge advances the address |
| hv_en | input | 1 | High-voltage enable level, part of the mode code |
| strobe_n | input | 1 | Active-low program strobe |
| mode_sel | input | 4 | Operation select pins |
| data_in | input | 8 | Data port, inbound |
| data_out | output | 8 | Data port, outbound |
| data_oe | output | 1 | Data port output enable |
| ready | output | 1 | High when no self-timed write is running |

## Verification
The counter is never visible directly. A wrong address therefore shows only when a later read or signature access returns another byte. The signature reads at 0, 1 and after wrap-around expose counter errors within one access. A timer that is off by one shows at once as a `ready` low time other than WRITE_CYC, or as an erase that fires on a hold one cycle too short. Protection-bit errors show on the next refused or accepted strobe through `ready`, and on the next code read through `data_oe`. A wrong AND merge or polling mask shows on the first read after the write and during the busy window. Random addresses and data are checked against a byte model held in the bench.

// File: rtl/fpc_pkg.sv
// Shared definitions for the flash programming controller.
// Assumes: operation codes are {hv_en, mode_sel[3:0]} and are all distinct.
package fpc_pkg;

    localparam int NUM_OPS = 6;
    localparam int OPI_WRC = 0;   // write code byte
    localparam int OPI_RDC = 1;   // read code byte
    localparam int OPI_LB1 = 2;   // write protection bit 1
    localparam int OPI_LB2 = 3;   // write protection bit 2
    localparam int OPI_ERA = 4;   // chip erase
    localparam int OPI_SIG = 5;   // read signature

    // Kind of self-timed write currently running
    typedef enum logic [1:0] {
        WK_CODE = 2'd0,
        WK_LB1  = 2'd1,
        WK_LB2  = 2'd2
    } wkind_e;

    // Pin code {hv_en, mode_sel} for each operation index
    function automatic logic [4:0] op_code(input int idx);
        case (idx)
            OPI_WRC: return 5'b1_1110;
            OPI_RDC: return 5'b0_1100;
            OPI_LB1: return 5'b1_1111;
            OPI_LB2: return 5'b1_1100;
            OPI_ERA: return 5'b1_1000;
            default: return 5'b0_0000;
        endcase
    endfunction

endpackage

// File: rtl/fpc_addr_counter.sv
// Address counter for programming mode.
// Clears when programming is entered and steps on each step pulse.
// Assumes: all inputs are synchronous to clk.
module fpc_addr_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              step_in,
    output logic [ADDR_W-1:0] addr
);

    logic pgm_q;
    logic step_q;
    logic pgm_rise;
    logic step_rise;

    assign pgm_rise  = pgm_en & ~pgm_q;
    assign step_rise = step_in & ~step_q & pgm_en;

    // Purpose: remember previous input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_q  <= 1'b0;
            step_q <= 1'b0;
        end else begin
            pgm_q  <= pgm_en;
            step_q <= step_in;
        end
    end

    // Purpose: clear on entry, advance on step, wrap naturally
    always_ff @(posedge clk) begin
        if (!rst_n)         addr <= '0;
        else if (pgm_rise)  addr <= '0;
        else if (step_rise) addr <= addr + ADDR_W'(1);
    end

    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_rise |=> (addr == '0)); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !pgm_rise) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R1

endmodule

// File: rtl/fpc_op_decode.sv
// One-hot operation decoder from the high-voltage level and mode pins.
// Assumes: codes from fpc_pkg::op_code are distinct; unlisted codes decode to all zero.
module fpc_op_decode
    import fpc_pkg::*;
(
    input  logic               pgm_en,
    input  logic               hv_en,
    input  logic [3:0]         mode_sel,
    output logic [NUM_OPS-1:0] op_oh
);

    logic [4:0] pins;
    assign pins = {hv_en, mode_sel};

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        localparam logic [4:0] CODE = op_code(gi);
        // Purpose: match one operation code
        always_comb op_oh[gi] = pgm_en && (pins == CODE);
    end

endmodule

// File: rtl/fpc_array.sv
// Behavioural flash array: a write ANDs new data into a byte, and erase sets all bytes to ones.
// Assumes: system reset models a blank, freshly erased array.
module fpc_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: blank on reset or erase, merge programmed bits on write
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[0] == '1)); // R6

endmodule

// File: rtl/fpc_flash_prog.sv
// Programming-mode controller: sequences self-timed writes, erase, protection bits and reads.
// Assumes: inputs are synchronous to clk; durations are given in clk cycles.
module fpc_flash_prog
    import fpc_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter int                DATA_W    = 8,
    parameter int                WRITE_CYC = 24,
    parameter int                ERASE_CYC = 40,
    parameter logic [DATA_W-1:0] SIG_MFR   = 8'h1E,
    parameter logic [DATA_W-1:0] SIG_DEV   = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              step_in,
    input  logic              hv_en,
    input  logic              strobe_n,
    input  logic [3:0]        mode_sel,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ready
);

    localparam int TW = $clog2(WRITE_CYC + 1);
    localparam int EW = $clog2(ERASE_CYC + 1);

    logic [ADDR_W-1:0]  addr;
    logic [NUM_OPS-1:0] op_oh;
    logic [DATA_W-1:0]  rd_data;

    logic               stb_q;
    logic               stb_rise;
    logic               busy;
    logic [TW-1:0]      tmr;
    wkind_e             kind;
    logic [ADDR_W-1:0]  w_addr;
    logic [DATA_W-1:0]  w_data;
    logic               commit;
    logic               lock1;
    logic               lock2;
    logic [EW-1:0]      er_cnt;
    logic               er_done;
    logic               erase_fire;
    logic               go_code;
    logic               go_lb1;
    logic               go_lb2;
    logic               poll_hit;

    fpc_addr_counter #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgm_en  (pgm_en),
        .step_in (step_in),
        .addr    (addr)
    );

    fpc_op_decode i_dec (
        .pgm_en   (pgm_en),
        .hv_en    (hv_en),
        .mode_sel (mode_sel),
        .op_oh    (op_oh)
    );

    fpc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase_fire),
        .we    (commit && kind == WK_CODE),
        .waddr (w_addr),
        .wdata (w_data),
        .raddr (addr),
        .rdata (rd_data)
    );

    assign stb_rise = strobe_n & ~stb_q;
    assign go_code  = stb_rise & op_oh[OPI_WRC] & ~busy & ~lock1;
    assign go_lb1   = stb_rise & op_oh[OPI_LB1] & ~busy;
    assign go_lb2   = stb_rise & op_oh[OPI_LB2] & ~busy;
    assign commit   = busy && (tmr == '0);

    // Purpose: previous strobe level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= strobe_n;
    end

    // Purpose: self-timed write sequencer, latching target and data at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tmr    <= '0;
            kind   <= WK_CODE;
            w_addr <= '0;
            w_data <= '0;
        end else if (busy) begin
            if (tmr == '0) busy <= 1'b0;
            else           tmr  <= tmr - TW'(1);
        end else if (go_code || go_lb1 || go_lb2) begin
            busy   <= 1'b1;
            tmr    <= TW'(WRITE_CYC - 1);
            kind   <= go_code ? WK_CODE : (go_lb1 ? WK_LB1 : WK_LB2);
            w_addr <= addr;
            w_data <= data_in;
        end
    end

    // Purpose: measure strobe-low hold in erase mode and fire once per hold
    always_ff @(posedge clk) begin
        if (!rst_n || strobe_n || !op_oh[OPI_ERA] || busy) begin
            er_cnt  <= '0;
            er_done <= 1'b0;
        end else if (!er_done) begin
            if (er_cnt == EW'(ERASE_CYC - 1)) er_done <= 1'b1;
            else                              er_cnt  <= er_cnt + EW'(1);
        end
    end

    assign erase_fire = !strobe_n && op_oh[OPI_ERA] && !busy && !er_done
                        && (er_cnt == EW'(ERASE_CYC - 1));

    // Purpose: protection bits, set by their writes and cleared only by erase
    always_ff @(posedge clk) begin
        if (!rst_n || erase_fire) begin
            lock1 <= 1'b0;
            lock2 <= 1'b0;
        end else if (commit) begin
            if (kind == WK_LB1) lock1 <= 1'b1;
            if (kind == WK_LB2) lock2 <= 1'b1;
        end
    end

    assign poll_hit = busy && (kind == WK_CODE) && (addr == w_addr);

    // Purpose: data port mux for code read, polling and signature
    always_comb begin
        data_oe  = 1'b0;
        data_out = '0;
        if (op_oh[OPI_RDC] && !(lock1 && lock2)) begin
            data_oe  = 1'b1;
            data_out = poll_hit ? {~w_data[DATA_W-1], w_data[DATA_W-2:0]} : rd_data;
        end else if (op_oh[OPI_SIG]) begin
            data_oe = 1'b1;
            if (addr == ADDR_W'(0))      data_out = SIG_MFR;
            else if (addr == ADDR_W'(1)) data_out = SIG_DEV;
        end
    end

    assign ready = ~busy;

    AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1 && ready && stb_rise && op_oh[OPI_WRC]) |=> ready); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1 && !erase_fire) |=> lock1); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr != '0) |=> (busy && $stable(w_addr) && $stable(w_data))); // R5
    AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1 && lock2 && op_oh[OPI_RDC]) |-> !data_oe); // R8
    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |-> !data_oe); // R10

endmodule

// File: tb/test_fpc_flash_prog.sv
module test_fpc_flash_prog;

    localparam int CLK_P     = 10;
    localparam int WRITE_CYC = 24;
    localparam int ERASE_CYC = 40;
    localparam int DEPTH     = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pgm_en = 1'b0;
    logic       step_in = 1'b0;
    logic       hv_en = 1'b0;
    logic       strobe_n = 1'b1;
    logic [3:0] mode_sel = 4'h0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       ready;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] mdl [DEPTH];
    bit         ml1 = 0;
    bit         ml2 = 0;

    always #(CLK_P/2) clk = ~clk;

    fpc_flash_prog #(.WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) i_fpc_flash_prog (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .step_in(step_in), .hv_en(hv_en),
        .strobe_n(strobe_n), .mode_sel(mode_sel), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .ready(ready)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected code-read result from the bench model
    function automatic bit exp_oe_rd();
        return !(ml1 && ml2);
    endfunction

    function automatic logic [7:0] exp_sig(input int a);
        return (a == 0) ? 8'h1E : ((a == 1) ? 8'h21 : 8'h00);
    endfunction

    task automatic set_mode(input logic hv, input logic [3:0] m);
        hv_en = hv; mode_sel = m;
    endtask

    task automatic enter();
        pgm_en = 1'b0; tick();
        pgm_en = 1'b1; tick();
    endtask

    task automatic step();
        step_in = 1'b1; tick();
        step_in = 1'b0; tick();
    endtask

    task automatic goto_addr(input int a);
        enter();
        for (int i = 0; i < a; i++) step();
    endtask

    task automatic strobe_pulse();
        strobe_n = 1'b0; tick();
        strobe_n = 1'b1; tick();
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin n++; tick(); end
    endtask

    task automatic rd_chk(input string tag, input int a);
        set_mode(1'b0, 4'b1100); #1;
        if (exp_oe_rd())
            chk(data_oe && data_out == mdl[a], tag, {23'd0, data_oe, data_out}, {24'd1, mdl[a]});
        else
            chk(!data_oe, tag, int'(data_oe), 0);
    endtask

    task automatic erase_hold(input int k);
        set_mode(1'b1, 4'b1000);
        strobe_n = 1'b0;
        repeat (k) tick();
        strobe_n = 1'b1; tick();
        if (k >= ERASE_CYC) begin
            for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
            ml1 = 0; ml2 = 0;
        end
    endtask

    task automatic lock_write(input bit which2);
        int n;
        set_mode(1'b1, which2 ? 4'b1100 : 4'b1111);
        strobe_pulse();
        wait_ready(n);
        if (which2) ml2 = 1; else ml1 = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        int a;
        logic [7:0] d;
        logic [7:0] exp_poll;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;

        repeat (3) tick();
        chk(ready == 1'b1, "R11 ready after reset", int'(ready), 1);
        chk(data_oe == 1'b0, "R11 oe after reset", int'(data_oe), 0);
        rst_n = 1'b1; tick();

        // R9 and R1: signature and counter clear/step
        enter();
        set_mode(1'b0, 4'b0000); #1;
        chk(data_oe && data_out == 8'h1E, "R9 sig addr0", data_out, 8'h1E);
        step(); #1;
        chk(data_out == 8'h21, "R9 sig addr1", data_out, 8'h21);
        step(); #1;
        chk(data_out == 8'h00, "R9 sig addr2", data_out, 8'h00);
        enter(); #1;
        chk(data_out == 8'h1E, "R1 clear on entry", data_out, 8'h1E);

        // R11: blank array reads FF
        rd_chk("R11 blank read", 0);

        // R10: no drive in write mode or when programming is off
        set_mode(1'b1, 4'b1110); #1;
        chk(!data_oe, "R10 oe in write mode", int'(data_oe), 0);
        set_mode(1'b0, 4'b1100); pgm_en = 1'b0; #1;
        chk(!data_oe, "R10 oe with pgm_en low", int'(data_oe), 0);
        pgm_en = 1'b1; tick();

        // R3 R4: random writes with polling and exact busy length
        for (int it = 0; it < 14; it++) begin
            a = int'($urandom % 24);
            d = 8'($urandom);
            goto_addr(a);
            set_mode(1'b1, 4'b1110);
            data_in = d;
            strobe_pulse();
            set_mode(1'b0, 4'b1100); #1;
            exp_poll = {~d[7], d[6:0]};
            chk(data_oe && data_out == exp_poll, "R4 polling value", data_out, exp_poll);
            wait_ready(n);
            chk(n == WRITE_CYC, "R3 busy length", n, WRITE_CYC);
            mdl[a] = mdl[a] & d;
            rd_chk("R3 merged byte", a);
        end

        // R3: a second write into a non-blank byte only clears bits
        goto_addr(30);
        set_mode(1'b1, 4'b1110); data_in = 8'h0F; strobe_pulse(); wait_ready(n);
        set_mode(1'b1, 4'b1110); data_in = 8'hF5; strobe_pulse(); wait_ready(n);
        mdl[30] = 8'h05;
        rd_chk("R3 AND merge 0F/F5", 30);

        // R5: strobe during busy is ignored
        goto_addr(40);
        set_mode(1'b1, 4'b1110); data_in = 8'h5A; strobe_pulse();
        data_in = 8'h00; strobe_pulse();
        wait_ready(n);
        chk(n == WRITE_CYC - 2, "R5 busy unchanged", n, WRITE_CYC - 2);
        mdl[40] = 8'h5A;
        rd_chk("R5 first data kept", 40);

        // R2: unlisted code has no effect
        goto_addr(41);
        set_mode(1'b1, 4'b0101); data_in = 8'h00; #1;
        chk(!data_oe, "R2 unlisted no drive", int'(data_oe), 0);
        strobe_pulse();
        chk(ready == 1'b1, "R2 unlisted strobe ignored", int'(ready), 1);
        rd_chk("R2 byte untouched", 41);

        // R1: wrap from 7FF to 000
        goto_addr(DEPTH - 1);
        set_mode(1'b0, 4'b0000); #1;
        chk(data_out == 8'h00, "R1 sig at 7FF", data_out, 8'h00);
        step(); #1;
        chk(data_out == 8'h1E, "R1 wrap to 000", data_out, exp_sig(0));

        // R7: protection bit 1 refuses writes, reads still allowed (R8)
        goto_addr(50);
        lock_write(1'b0);
        set_mode(1'b1, 4'b1110); data_in = 8'h00; strobe_pulse();
        chk(ready == 1'b1, "R7 locked write refused", int'(ready), 1);
        rd_chk("R7 byte kept / R8 read with lock1", 50);

        // R8: both protection bits block reads
        lock_write(1'b1);
        goto_addr(3);
        rd_chk("R8 read blocked", 3);

        // R6: short hold does nothing, full hold erases
        erase_hold(ERASE_CYC - 1);
        rd_chk("R6 short hold keeps locks", 3);
        erase_hold(ERASE_CYC);
        rd_chk("R6 erase clears locks", 3);
        goto_addr(30);
        rd_chk("R6 erased byte FF", 30);
        set_mode(1'b1, 4'b1110); data_in = 8'hA0; strobe_pulse(); wait_ready(n);
        chk(n == WRITE_CYC, "R6 write after erase accepted", n, WRITE_CYC);
        mdl[30] = 8'hA0;
        rd_chk("R6 rewrite after erase", 30);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule